// File: doc/BRIEF.md
# EEPROM Configuration Load Sequencer

This block decides when a device pulls its configuration out of an external EEPROM over a shared two-wire bus. A separate bus-master engine does the actual transfer. The sequencer only hands that engine a one-cycle start request, then waits for the engine to report done or error.

A load can begin in two ways:
- When the device is strapped as bus master, a falling edge on the active-low read-enable pin starts a load.
- A rising edge on the software immediate-trigger bit starts a load at once, whatever the strap and the pin are doing.

A load runs once and then locks out. Only the software master-mode reset bit re-arms it. That bit is a level and software clears it. A software disable bit holds off a load, but only while the sequencer is armed and waiting. An error reported by the engine parks the sequencer in a failed state that only a power-on reset leaves.

The states are armed-idle, loading, done, disabled and failed.

Two input combinations have no defined outcome:
- disable and immediate trigger set together;
- master-mode reset used while not strapped as master.

For the first of these, this design lets disable win.

None of the pins carries a data stream, so all of them are plain control and status levels with no valid/ready handshake. The read-enable pin is asynchronous and passes through `SYNC_STAGES` flip-flops before its edge is detected. The software bits are taken as already synchronous.

Top module: `cfg_load_seq`

## Requirements
- R1: After power-on reset (`rst_n` low) the sequencer is armed and idle, and `eng_start`, `load_busy`, `load_done` and `load_failed` are all 0.
- R2: While armed, with `strap_master` = 1, a high-to-low transition of `rd_en_n` issues exactly one start request. With `strap_master` = 0 the pin has no effect.
- R3: While armed, a 0-to-1 transition of `trig_now` issues one start request whatever the values of `strap_master` and `rd_en_n`.
- R4: `eng_start` is high for exactly one cycle per load. A pin held low or a trigger bit held high starts at most one load, and `load_busy` is 1 from the start request until done or error.
- R5: `eng_done` sampled during a load sets `load_done`, clears `load_busy`, and `load_done` stays 1 until a master-mode reset.
- R6: Once a load has completed, new edges on `trig_now` or `rd_en_n` issue no start request.
- R7: While `mm_reset` is 1, the done and disabled states return to armed, `load_done` clears, and no load starts. After `mm_reset` returns to 0, a new edge on the pin or the trigger starts a load.
- R8: `mm_disable` = 1 while armed blocks every start. When `mm_disable` returns to 0 the sequencer is armed again, and a fresh edge is needed to start a load.
- R9: During a load, `mm_disable`, `mm_reset` and new trigger or pin edges have no effect, and the load still completes.
- R10: `eng_err` sampled during a load sets `load_failed`, and error wins over a simultaneous done. The failed state ignores master-mode reset and triggers until power-on reset.
- R11: `eng_done` and `eng_err` are ignored outside a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous release |
| strap_master | input | 1 | Decoded strap: 1 = device acts as bus master |
| rd_en_n | input | 1 | Read-enable pin, active low, asynchronous |
| trig_now | input | 1 | Software immediate-trigger bit (level) |
| mm_reset | input | 1 | Software master-mode reset bit (level, held by software) |
| mm_disable | input | 1 | Software master-mode disable bit (level) |
| eng_start | output | 1 | One-cycle start request to the bus-master engine |
| eng_done | input | 1 | Engine reports a completed load |
| eng_err | input | 1 | Engine reports a failed load |
| load_done | output | 1 | Sticky load-complete status |
| load_busy | output | 1 | A load is in progress |
| load_failed | output | 1 | Load failed; cleared only by power-on reset |

## Verification
A wrong state register shows at the ports within one cycle in two ways:
- the busy, done or failed flags disagree with the history of stimulus so far;
- a start request appears or goes missing after the next trigger or pin edge.

A broken edge detector or synchronizer shows as a missing start, or as a second start while a level is held. This is visible a few cycles after the pin or bit changes. A lost lock-out or a lost failed-state hold shows as an extra start request the first time software or the pin tries again.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_DONE = 3'd2,
    ST_OFF  = 3'd3,
    ST_FAIL = 3'd4
  } seq_st_t;
endpackage

// File: rtl/cls_edge.sv
// Level-to-event converter with an optional synchronizer chain in front.
module cls_edge #(
  parameter int SYNC = 2,   // synchronizer flops; 0 = input already synchronous
  parameter bit FALL = 1'b1 // 1: detect high-to-low, 0: detect low-to-high
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic evt_o
);
  // History starts at the inactive level so a level already active at reset counts once.
  localparam logic IDLE_LVL = FALL ? 1'b1 : 1'b0;

  logic cur, prev;

  if (SYNC == 0) begin : g_direct
    assign cur = lvl_i;
  end else begin : g_sync
    logic [SYNC-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh <= {SYNC{IDLE_LVL}};
      end else begin
        sh[0] <= lvl_i;
        for (int i = 1; i < SYNC; i++) sh[i] <= sh[i-1];
      end
    end
    assign cur = sh[SYNC-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= IDLE_LVL;
    else        prev <= cur;
  end

  assign evt_o = FALL ? (prev & ~cur) : (~prev & cur);

  // R4: a single level change gives one event, never two in a row
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/cls_fsm.sv
module cls_fsm
  import cls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_master_i,
  input  logic pin_evt_i,
  input  logic trig_evt_i,
  input  logic mm_reset_i,
  input  logic mm_disable_i,
  input  logic eng_done_i,
  input  logic eng_err_i,
  output logic eng_start_o,
  output logic load_done_o,
  output logic load_busy_o,
  output logic load_failed_o
);
  seq_st_t st_q, st_d;
  logic    start_q, start_d;
  logic    done_q, done_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    done_d  = done_q;
    unique case (st_q)
      ST_IDLE: begin
        if (mm_reset_i) begin
          st_d = ST_IDLE;                // held in armed state while reset bit is set
        end else if (mm_disable_i) begin
          st_d = ST_OFF;                 // disable wins over a simultaneous trigger
        end else if (trig_evt_i || (strap_master_i && pin_evt_i)) begin
          st_d    = ST_LOAD;
          start_d = 1'b1;
        end
      end
      ST_LOAD: begin
        if (eng_err_i) begin
          st_d = ST_FAIL;
        end else if (eng_done_i) begin
          st_d   = ST_DONE;
          done_d = 1'b1;
        end
      end
      ST_DONE: begin
        if (mm_reset_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b0;
        end
      end
      ST_OFF: begin
        if (mm_reset_i || !mm_disable_i) st_d = ST_IDLE;
      end
      ST_FAIL: st_d = ST_FAIL;
      default: st_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign eng_start_o   = start_q;
  assign load_done_o   = done_q;
  assign load_busy_o   = (st_q == ST_LOAD);
  assign load_failed_o = (st_q == ST_FAIL);

  // R4: start request lasts one cycle
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);
  // R4: a start request coincides with entry into the loading state
  a_r4_start_enters_load: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> (load_busy_o && $past(st_q) == ST_IDLE));
  // R5: done status is sticky until master-mode reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done_o && !mm_reset_i) |=> load_done_o);
  // R6: completed state issues no start
  a_r6_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> !eng_start_o);
  // R9: disable and reset do not disturb a load without engine response
  a_r9_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy_o && !eng_done_i && !eng_err_i) |=> load_busy_o);
  // R10: failed state is permanent until power-on reset
  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_failed_o |=> (load_failed_o && !eng_start_o));
  // R11: done status never rises outside a load
  a_r11_done_only_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done_o) |-> ($past(st_q) == ST_LOAD));
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_master,
  input  logic rd_en_n,
  input  logic trig_now,
  input  logic mm_reset,
  input  logic mm_disable,
  output logic eng_start,
  input  logic eng_done,
  input  logic eng_err,
  output logic load_done,
  output logic load_busy,
  output logic load_failed
);
  logic pin_evt, trig_evt;

  cls_edge #(.SYNC(SYNC_STAGES), .FALL(1'b1)) u_pin_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(rd_en_n), .evt_o(pin_evt)
  );

  cls_edge #(.SYNC(0), .FALL(1'b0)) u_trig_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(trig_now), .evt_o(trig_evt)
  );

  cls_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .strap_master_i(strap_master),
    .pin_evt_i(pin_evt), .trig_evt_i(trig_evt),
    .mm_reset_i(mm_reset), .mm_disable_i(mm_disable),
    .eng_done_i(eng_done), .eng_err_i(eng_err),
    .eng_start_o(eng_start), .load_done_o(load_done),
    .load_busy_o(load_busy), .load_failed_o(load_failed)
  );

  // R1: no activity on the engine handshake while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!eng_start);
  end
endmodule

// File: tb/test_cfg_load_seq.sv
`timescale 1ns/1ps
module test_cfg_load_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_master = 1'b0, rd_en_n = 1'b1, trig_now = 1'b0;
  logic mm_reset = 1'b0, mm_disable = 1'b0;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic eng_start, load_done, load_busy, load_failed;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_load_seq i_cfg_load_seq (
    .clk(clk), .rst_n(rst_n), .strap_master(strap_master), .rd_en_n(rd_en_n),
    .trig_now(trig_now), .mm_reset(mm_reset), .mm_disable(mm_disable),
    .eng_start(eng_start), .eng_done(eng_done), .eng_err(eng_err),
    .load_done(load_done), .load_busy(load_busy), .load_failed(load_failed)
  );

  always @(posedge clk) if (rst_n && eng_start) starts++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0;
    strap_master = 1'b0; rd_en_n = 1'b1; trig_now = 1'b0;
    mm_reset = 1'b0; mm_disable = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
    step(3);
    rst_n = 1'b1;
    starts = 0;
    step(2);
  endtask

  task automatic respond(input logic d, input logic e);
    eng_done = d; eng_err = e;
    step(1);
    eng_done = 1'b0; eng_err = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    por();
    step(10);
    check("R1 busy", load_busy, 0);
    check("R1 done", load_done, 0);
    check("R1 failed", load_failed, 0);
    check("R1 starts", starts, 0);

    // R11: engine responses outside a load are ignored
    respond(1'b1, 1'b0);
    check("R11 done while idle", load_done, 0);
    respond(1'b0, 1'b1);
    check("R11 err while idle", load_failed, 0);

    // Sweep: strap x source (0 pin, 1 trigger) x disable -> R2, R3, R8
    for (int s = 0; s < 2; s++) begin
      for (int src = 0; src < 2; src++) begin
        for (int dis = 0; dis < 2; dis++) begin
          int exp_st;
          por();
          strap_master = s[0];
          mm_disable = dis[0];
          if (src == 1 && s == 0) rd_en_n = 1'b0; // R3: pin state irrelevant
          step(4);
          if (src == 0) rd_en_n = 1'b0; else trig_now = 1'b1;
          step(6);
          exp_st = (dis == 0 && (src == 1 || s == 1)) ? 1 : 0;
          if (src == 0) check("R2 pin start", starts, exp_st);
          else          check("R3 trigger start", starts, exp_st);
          check("R4 busy follows start", load_busy, exp_st);
          if (dis == 1) begin
            mm_disable = 1'b0;
            step(6);
            check("R8 re-armed needs new edge", starts, 0);
            if (src == 0) begin rd_en_n = 1'b1; step(4); rd_en_n = 1'b0; end
            else begin trig_now = 1'b0; step(1); trig_now = 1'b1; end
            step(6);
            check("R8 start after disable cleared", starts, (src == 1 || s == 1) ? 1 : 0);
          end
        end
      end
    end

    // Main flow: pin start, hold, interference, completion
    por();
    strap_master = 1'b1;
    step(2);
    rd_en_n = 1'b0;
    step(15);
    check("R4 held pin one start", starts, 1);
    trig_now = 1'b1;
    step(3);
    check("R9 trigger during load", starts, 1);
    mm_disable = 1'b1; mm_reset = 1'b1;
    step(4);
    check("R9 busy under disable/reset", load_busy, 1);
    mm_disable = 1'b0; mm_reset = 1'b0;
    step(2);
    check("R9 still loading", load_busy, 1);
    respond(1'b1, 1'b0);
    check("R5 done set", load_done, 1);
    check("R5 busy cleared", load_busy, 0);
    step(20);
    check("R5 done sticky", load_done, 1);
    trig_now = 1'b0; step(2); trig_now = 1'b1;
    rd_en_n = 1'b1; step(4); rd_en_n = 1'b0;
    step(8);
    check("R6 locked out", starts, 1);
    respond(1'b0, 1'b1);
    check("R11 err while done", load_failed, 0);

    // R7: master-mode reset re-arms
    mm_reset = 1'b1;
    step(3);
    check("R7 done cleared", load_done, 0);
    rd_en_n = 1'b1; step(4); rd_en_n = 1'b0;
    step(6);
    check("R7 no start while reset held", starts, 1);
    mm_reset = 1'b0;
    trig_now = 1'b0; step(2); trig_now = 1'b1;
    step(4);
    check("R7 trigger after reset", starts, 2);
    respond(1'b1, 1'b0);
    mm_reset = 1'b1; step(2); mm_reset = 1'b0;
    rd_en_n = 1'b1; step(4); rd_en_n = 1'b0;
    step(6);
    check("R7 pin after reset", starts, 3);

    // R10: error wins over done, failed state is permanent
    respond(1'b1, 1'b1);
    check("R10 failed", load_failed, 1);
    check("R10 error beats done", load_done, 0);
    mm_reset = 1'b1; step(3); mm_reset = 1'b0;
    trig_now = 1'b0; step(2); trig_now = 1'b1;
    step(6);
    check("R10 reset ignored", load_failed, 1);
    check("R10 no start when failed", starts, 3);
    por();
    check("R10 power-on clears failure", load_failed, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule